// File: doc/BRIEF.md
# Ethernet Forwarding Mode Gate

This block sits on one ingress port of a switch and watches the received Ethernet byte stream. It decides when a frame may be handed to the forwarding path. Three policies are available, chosen per frame: early release once the destination address is in, release after the collision window has passed, or release only after the whole frame has arrived and its check sequence has been verified. While the frame streams in, the block captures the destination MAC address. At the last byte it reports whether the frame is accepted or dropped, and it counts dropped frames by cause.

The control is a small state machine. `ST_IDLE` waits for a start-of-frame byte. `ST_WAIT` holds an early-release frame until its threshold byte arrives. `ST_PASS` follows a frame that has already been released until its end. `ST_STORE` holds a full-check frame until its end. The transitions are as follows. A start byte moves the machine out of `ST_IDLE`, into `ST_STORE` for the full-check policy and into `ST_WAIT` otherwise. In `ST_WAIT`, the threshold byte moves it to `ST_PASS`. From any state, a start byte begins a new frame. From any state, the end byte returns it to `ST_IDLE`.

Top module: `fwd_mode_gate`

## Requirements
- R1: After reset, `release_o`, `accept_o` and `drop_o` are low, `dst_mac_o` is zero and all four error counters are zero.
- R2: `mode_sel` is sampled only on the byte that carries `rx_sof`. Its codes are 00 for early release at byte 6, 01 for release at byte 64, and 10 or 11 for release after the full check. Changing `mode_sel` mid-frame has no effect on that frame.
- R3: In mode 00, `release_o` pulses for one cycle, in the cycle after the 6th accepted byte of the frame.
- R4: In mode 01, `release_o` pulses for one cycle, in the cycle after the 64th accepted byte of the frame.
- R5: In mode 10 or 11, `release_o` pulses only for a good frame, in the same cycle as `accept_o`, which is the cycle after the last byte.
- R6: Once 6 bytes of a frame have been taken, `dst_mac_o` holds them, with the first byte in bits 47:40 and the sixth byte in bits 7:0.
- R7: In mode 00 or 01, a frame that ends before its release byte is dropped, never released, and counted in `frag_cnt_o`.
- R8: A frame shorter than 64 bytes that does not fall under R7 is dropped and counted in `runt_cnt_o`. This includes an already-released frame in mode 00.
- R9: A frame longer than 1518 bytes, FCS included, is dropped and counted in `giant_cnt_o`.
- R10: The FCS is checked with a reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) run over every byte, FCS included, with the FCS sent least significant byte first. The check register must end at 0xDEBB20E3, the bit-reversed form of 0xC704DD7B. A frame of legal length that fails this check is dropped and counted in `crc_cnt_o`.
- R11: Every frame end gives exactly one of `accept_o` or `drop_o`, in the cycle after the last byte, and at most one counter step. The causes rank fragment, then runt, then giant, then CRC.
- R12: Each error counter saturates at its all-ones value.
- R13: A byte with `rx_valid` low is ignored. A valid byte without `rx_sof` while `ST_IDLE` is ignored: it produces no strobe and changes no counter and no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | A byte is present on `rx_data` |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| mode_sel | input | 2 | Release policy, sampled at frame start |
| release_o | output | 1 | One-cycle pulse: the frame may be forwarded |
| dst_mac_o | output | 48 | Captured destination address |
| accept_o | output | 1 | One-cycle pulse: the frame ended good |
| drop_o | output | 1 | One-cycle pulse: the frame ended defective |
| runt_cnt_o | output | CNT_W | Short frame count |
| giant_cnt_o | output | CNT_W | Oversize frame count |
| crc_cnt_o | output | CNT_W | Bad FCS count |
| frag_cnt_o | output | CNT_W | Frames that ended before early release |

## Verification
The release decision and the end-of-frame verdict can fall in the same cycle. This happens when a frame's last byte is also its threshold byte: a 6-byte frame in mode 00, which is released and dropped as a runt at once, and a 64-byte frame in mode 01, which is released and accepted at once. In the full-check modes, release and accept always coincide. Directed frames of exactly these lengths are sent, and at the sample after the last byte the bench requires both the release pulse and the correct verdict. Random frames, with random gaps and random mode changes mid-frame, check that the release index and the verdict still follow the mode latched at the start byte.

// File: rtl/fwd_gate_pkg.sv
package fwd_gate_pkg;

    typedef enum logic [1:0] {
        MODE_CUT       = 2'b00,
        MODE_FRAG      = 2'b01,
        MODE_STORE     = 2'b10,
        MODE_STORE_ALT = 2'b11
    } fwd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PASS,
        ST_STORE
    } gate_state_e;

    typedef enum logic [2:0] {
        CL_GOOD,
        CL_FRAG,
        CL_RUNT,
        CL_GIANT,
        CL_CRC
    } frame_class_e;

    localparam int ERR_KINDS = 4;
    localparam int ERR_RUNT  = 0;
    localparam int ERR_GIANT = 1;
    localparam int ERR_CRC   = 2;
    localparam int ERR_FRAG  = 3;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_GOOD_REG  = 32'hDEBB_20E3;

    // one byte through the reflected CRC-32, low bit first
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i])
                r = (r >> 1) ^ CRC_POLY_REFL;
            else
                r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fwd_gate_crc.sv
module fwd_gate_crc
    import fwd_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic        first,
    input  logic [7:0]  data,
    output logic [31:0] crc_next
);

    logic [31:0] crc_q;
    logic [31:0] seed;

    assign seed     = first ? CRC_SEED : crc_q;
    assign crc_next = crc_byte(seed, data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= CRC_SEED;
        else if (byte_en)
            crc_q <= crc_next;
    end

endmodule

// File: rtl/fwd_gate_len.sv
module fwd_gate_len #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic             first,
    output logic [LEN_W-1:0] len_next
);

    localparam logic [LEN_W-1:0] LEN_TOP = '1;

    logic [LEN_W-1:0] len_q;

    always_comb begin
        if (first)
            len_next = LEN_W'(1);
        else if (len_q == LEN_TOP)
            len_next = len_q;
        else
            len_next = len_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_q <= '0;
        else if (byte_en)
            len_q <= len_next;
    end

endmodule

// File: rtl/fwd_gate_errcnt.sv
module fwd_gate_errcnt #(
    parameter int KINDS = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [KINDS-1:0]       inc,
    output logic [KINDS*CNT_W-1:0] counts
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    for (genvar k = 0; k < KINDS; k++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (inc[k] && cnt_q != CNT_TOP)
                cnt_q <= cnt_q + CNT_W'(1);
        end
        assign counts[k*CNT_W +: CNT_W] = cnt_q;
    end

endmodule

// File: rtl/fwd_mode_gate.sv
module fwd_mode_gate
    import fwd_gate_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int LEN_W     = 12,
    parameter int CUT_LEN   = 6,
    parameter int FRAG_LEN  = 64,
    parameter int MIN_LEN   = 64,
    parameter int MAX_LEN   = 1518,
    parameter int MAC_BYTES = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic                   rx_sof,
    input  logic                   rx_eof,
    input  logic [7:0]             rx_data,
    input  logic [1:0]             mode_sel,
    output logic                   release_o,
    output logic [MAC_BYTES*8-1:0] dst_mac_o,
    output logic                   accept_o,
    output logic                   drop_o,
    output logic [CNT_W-1:0]       runt_cnt_o,
    output logic [CNT_W-1:0]       giant_cnt_o,
    output logic [CNT_W-1:0]       crc_cnt_o,
    output logic [CNT_W-1:0]       frag_cnt_o
);

    localparam int MAC_W = MAC_BYTES * 8;

    gate_state_e  state_q, state_d, entry_state;
    fwd_mode_e    mode_q, mode_eff;
    frame_class_e cls;

    logic                 start, byte_en, end_f, is_store, hit, released;
    logic [LEN_W-1:0]     thr, len_next;
    logic [31:0]          crc_next;
    logic [ERR_KINDS-1:0] err_inc;
    logic [ERR_KINDS*CNT_W-1:0] err_counts;

    assign start    = rx_valid && rx_sof;
    assign byte_en  = rx_valid && (rx_sof || state_q != ST_IDLE);
    assign end_f    = byte_en && rx_eof;
    assign mode_eff = start ? fwd_mode_e'(mode_sel) : mode_q;
    assign is_store = (mode_eff == MODE_STORE) || (mode_eff == MODE_STORE_ALT);

    fwd_gate_len #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_en  (byte_en),
        .first    (start),
        .len_next (len_next)
    );

    fwd_gate_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_en  (byte_en),
        .first    (start),
        .data     (rx_data),
        .crc_next (crc_next)
    );

    // release threshold of the latched policy
    always_comb begin
        unique case (mode_eff)
            MODE_CUT:                   thr = LEN_W'(CUT_LEN);
            MODE_FRAG:                  thr = LEN_W'(FRAG_LEN);
            MODE_STORE, MODE_STORE_ALT: thr = '0;
        endcase
    end

    assign hit = byte_en && !is_store
              && (start || state_q == ST_WAIT)
              && (len_next == thr);

    assign released = hit || (state_q == ST_PASS && !start);

    // verdict for the byte now being taken, meaningful at frame end
    always_comb begin
        cls = CL_GOOD;
        if (!is_store && !released)
            cls = CL_FRAG;
        else if (len_next < LEN_W'(MIN_LEN))
            cls = CL_RUNT;
        else if (len_next > LEN_W'(MAX_LEN))
            cls = CL_GIANT;
        else if (crc_next != CRC_GOOD_REG)
            cls = CL_CRC;
    end

    assign entry_state = is_store ? ST_STORE : (hit ? ST_PASS : ST_WAIT);

    always_comb begin
        state_d = state_q;
        if (byte_en) begin
            unique case (state_q)
                ST_IDLE:  state_d = entry_state;
                ST_WAIT:  state_d = start ? entry_state : (hit ? ST_PASS : ST_WAIT);
                ST_PASS:  state_d = start ? entry_state : ST_PASS;
                ST_STORE: state_d = start ? entry_state : ST_STORE;
            endcase
            if (rx_eof)
                state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            release_o <= 1'b0;
            accept_o  <= 1'b0;
            drop_o    <= 1'b0;
            dst_mac_o <= '0;
            mode_q    <= MODE_CUT;
        end else begin
            release_o <= hit || (end_f && is_store && cls == CL_GOOD);
            accept_o  <= end_f && cls == CL_GOOD;
            drop_o    <= end_f && cls != CL_GOOD;
            if (start)
                mode_q <= fwd_mode_e'(mode_sel);
            if (byte_en && len_next <= LEN_W'(MAC_BYTES))
                dst_mac_o <= {dst_mac_o[MAC_W-9:0], rx_data};
        end
    end

    always_comb begin
        err_inc            = '0;
        err_inc[ERR_RUNT]  = end_f && cls == CL_RUNT;
        err_inc[ERR_GIANT] = end_f && cls == CL_GIANT;
        err_inc[ERR_CRC]   = end_f && cls == CL_CRC;
        err_inc[ERR_FRAG]  = end_f && cls == CL_FRAG;
    end

    fwd_gate_errcnt #(.KINDS(ERR_KINDS), .CNT_W(CNT_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (err_inc),
        .counts (err_counts)
    );

    assign runt_cnt_o  = err_counts[ERR_RUNT*CNT_W  +: CNT_W];
    assign giant_cnt_o = err_counts[ERR_GIANT*CNT_W +: CNT_W];
    assign crc_cnt_o   = err_counts[ERR_CRC*CNT_W   +: CNT_W];
    assign frag_cnt_o  = err_counts[ERR_FRAG*CNT_W  +: CNT_W];

endmodule

// File: rtl/fwd_mode_gate_chk.sv
module fwd_mode_gate_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             release_o,
    input logic             accept_o,
    input logic             drop_o,
    input logic [CNT_W-1:0] runt_cnt_o,
    input logic [CNT_W-1:0] giant_cnt_o,
    input logic [CNT_W-1:0] crc_cnt_o,
    input logic [CNT_W-1:0] frag_cnt_o
);

    // R11
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && drop_o));

    // R3
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);

    // R12
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_cnt_o >= $past(runt_cnt_o)) && (giant_cnt_o >= $past(giant_cnt_o))
        && (crc_cnt_o >= $past(crc_cnt_o)) && (frag_cnt_o >= $past(frag_cnt_o)));

    // R11
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({runt_cnt_o != $past(runt_cnt_o), giant_cnt_o != $past(giant_cnt_o),
                    crc_cnt_o != $past(crc_cnt_o), frag_cnt_o != $past(frag_cnt_o)}) <= 1);

    // R11
    count_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((runt_cnt_o != $past(runt_cnt_o)) || (giant_cnt_o != $past(giant_cnt_o))
         || (crc_cnt_o != $past(crc_cnt_o)) || (frag_cnt_o != $past(frag_cnt_o))) |-> drop_o);

endmodule

bind fwd_mode_gate fwd_mode_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .release_o   (release_o),
    .accept_o    (accept_o),
    .drop_o      (drop_o),
    .runt_cnt_o  (runt_cnt_o),
    .giant_cnt_o (giant_cnt_o),
    .crc_cnt_o   (crc_cnt_o),
    .frag_cnt_o  (frag_cnt_o)
);

// File: tb/fwd_mode_gate_test.sv
`timescale 1ns/1ps
module fwd_mode_gate_test;

    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic [1:0]    mode_sel = 2'b00;
    logic          release_o, accept_o, drop_o;
    logic [47:0]   dst_mac_o;
    logic [CW-1:0] runt_cnt_o, giant_cnt_o, crc_cnt_o, frag_cnt_o;

    int checks = 0, fails = 0;
    bit finished = 0;
    int exp_cnt [4];
    logic [7:0] fr [0:2047];
    int last_rel;

    always #2 clk = ~clk;

    fwd_mode_gate #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .mode_sel(mode_sel),
        .release_o(release_o), .dst_mac_o(dst_mac_o), .accept_o(accept_o),
        .drop_o(drop_o), .runt_cnt_o(runt_cnt_o), .giant_cnt_o(giant_cnt_o),
        .crc_cnt_o(crc_cnt_o), .frag_cnt_o(frag_cnt_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++)
            r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    // expected release byte index, 0 when none
    function automatic int model_rel(input int mode, input int len, input bit good);
        if (mode == 0) return (len >= 6) ? 6 : 0;
        if (mode == 1) return (len >= 64) ? 64 : 0;
        return good ? len : 0;
    endfunction

    // 0 good 1 frag 2 runt 3 giant 4 crc
    function automatic int model_cls(input int mode, input int len, input bit crc_ok);
        if (mode < 2 && len < ((mode == 0) ? 6 : 64)) return 1;
        if (len < 64) return 2;
        if (len > 1518) return 3;
        if (!crc_ok) return 4;
        return 0;
    endfunction

    task automatic send_frame(input int mode, input int len, input bit corrupt, input int mid_mode);
        logic [31:0] c;
        int cls, rel, rel_at, early;
        bit acc, drp, crc_ok;
        string rtag;
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
        if (len >= 10) begin
            c = 32'hFFFFFFFF;
            for (int i = 0; i < len - 4; i++) c = crc_step(c, fr[i]);
            c = ~c;
            for (int k = 0; k < 4; k++) fr[len-4+k] = c[8*k +: 8];
        end
        if (corrupt) fr[$urandom % len] ^= 8'h10;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) c = crc_step(c, fr[i]);
        crc_ok = (c == 32'hDEBB20E3);
        cls = model_cls(mode, len, crc_ok);
        rel = model_rel(mode, len, cls == 0);
        rel_at = 0; early = 0; acc = 0; drp = 0;
        for (int i = 0; i < len; i++) begin
            if (i > 0 && ($urandom % 5) == 0) begin
                rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'($urandom);
                @(negedge clk);
                if (release_o || accept_o || drop_o) early++;
            end
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fr[i];
            mode_sel = (i == 0) ? 2'(mode) : ((mid_mode >= 0) ? 2'(mid_mode) : 2'($urandom));
            @(negedge clk);
            if (release_o) rel_at = (rel_at == 0) ? i + 1 : -1;
            if (i == len - 1) begin acc = accept_o; drp = drop_o; end
            else if (accept_o || drop_o) early++;
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        last_rel = rel_at;
        rtag = (mode == 0) ? "R3 mode 00 release" : (mode == 1) ? "R4 mode 01 release" : "R5 full-check release";
        if (rel == 0 && mode < 2) rtag = "R7 no release for fragment";
        chk(rtag, rel_at, rel);
        chk("R11 single verdict at end", {early[7:0], 6'd0, acc, drp}, {8'd0, 6'd0, cls == 0, cls != 0});
        if (cls == 1) exp_cnt[3] = (exp_cnt[3] < CMAX) ? exp_cnt[3] + 1 : CMAX;
        if (cls == 2) exp_cnt[0] = (exp_cnt[0] < CMAX) ? exp_cnt[0] + 1 : CMAX;
        if (cls == 3) exp_cnt[1] = (exp_cnt[1] < CMAX) ? exp_cnt[1] + 1 : CMAX;
        if (cls == 4) exp_cnt[2] = (exp_cnt[2] < CMAX) ? exp_cnt[2] + 1 : CMAX;
        chk((exp_cnt[3] == CMAX) ? "R7 R12 frag count" : "R7 frag count", frag_cnt_o, exp_cnt[3]);
        chk((exp_cnt[0] == CMAX) ? "R8 R12 runt count" : "R8 runt count", runt_cnt_o, exp_cnt[0]);
        chk("R9 giant count", giant_cnt_o, exp_cnt[1]);
        chk("R10 crc count", crc_cnt_o, exp_cnt[2]);
        if (len >= 6)
            chk("R6 destination address", dst_mac_o,
                {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int seed, m, l;
        logic [47:0] mac_before;
        seed = $urandom(32'd7919);
        for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {release_o, accept_o, drop_o}, 3'b000);
        chk("R1 reset address", dst_mac_o, 48'd0);
        chk("R1 reset counters", {runt_cnt_o, giant_cnt_o, crc_cnt_o, frag_cnt_o}, '0);
        rst_n = 1;
        @(negedge clk);

        // stray valid bytes with no frame open
        mac_before = dst_mac_o;
        for (int i = 0; i < 4; i++) begin
            rx_valid = 1; rx_sof = 0; rx_eof = (i == 3); rx_data = 8'hA5; mode_sel = 2'b00;
            @(negedge clk);
            chk("R13 stray byte strobes", {release_o, accept_o, drop_o}, 3'b000);
        end
        rx_valid = 0; rx_eof = 0;
        chk("R13 stray byte address", dst_mac_o, mac_before);
        chk("R13 stray byte counters", {runt_cnt_o, giant_cnt_o, crc_cnt_o, frag_cnt_o}, '0);

        // directed corners
        send_frame(0, 5, 0, -1);     // fragment before byte 6
        send_frame(0, 6, 0, -1);     // release and runt drop together
        send_frame(0, 63, 0, -1);
        send_frame(0, 64, 0, 2);     // mid-frame switch to full check
        chk("R2 mode latched at start", last_rel, 6);
        send_frame(1, 63, 0, -1);    // fragment before byte 64
        send_frame(1, 64, 0, -1);    // release and accept together
        send_frame(1, 200, 0, 0);
        chk("R2 mode latched at start", last_rel, 64);
        send_frame(2, 63, 0, -1);
        send_frame(2, 64, 0, 0);
        chk("R2 mode latched at start", last_rel, 64);
        send_frame(3, 1518, 0, -1);
        send_frame(2, 1519, 0, -1);
        send_frame(0, 1519, 0, -1);
        send_frame(2, 100, 1, -1);
        send_frame(0, 100, 1, -1);
        send_frame(3, 300, 1, -1);

        for (int n = 0; n < 80; n++) begin
            m = $urandom % 4;
            l = (($urandom % 4) == 0) ? 1400 + ($urandom % 200) : 1 + ($urandom % 130);
            send_frame(m, l, ($urandom % 4) == 0, -1);
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule